// File: doc/BRIEF.md
# Per-Flow Credit-Gated Transmit Scheduler

This block sits between a segment selector and the outgoing link. The selector hands it pairs of flow number and segment number. Each flow keeps its own first-in first-out list of pending segment numbers and its own byte credit. A flow may send its oldest pending segment only while its credit covers one segment. Every segment has the same size, which is a parameter. Among the flows that may send, one is picked per clock in round-robin order. The pick leaves as a transmit request. One clock later it is echoed back to the selector as a "segment sent" notice.

How credit is kept is fixed at build time by a mode parameter, and there are three modes.

- **Window mode** tracks a congestion window and the bytes in flight. Acknowledgements open the window and congestion notices close it.
- **Rate mode** refills credit from a free-running internal tick counter, up to a burst ceiling.
- **Grant mode** adds the byte count carried by each received grant token.

Feedback inputs that do not belong to the chosen mode are ignored.

Top module: `ftx_sched`

## Requirements
- R1: While reset is held and on the first clock after it, tx_valid and done_valid are low. Every queue starts empty. In window mode the window starts at one segment with nothing in flight. In rate and grant mode the credit starts at zero.
- R2: Each flow queue holds QDEPTH entries and releases them in arrival order. An enqueue to a queue that already held QDEPTH entries at the start of that cycle is discarded, even if that queue sends in the same cycle. A discarded segment never appears on tx_seg.
- R3: A flow may send only when its queue is non-empty and its credit covers SEG_BYTES. In window mode that means in-flight bytes plus SEG_BYTES do not exceed the window. In rate and grant mode it means credit is at least SEG_BYTES. Each send adds SEG_BYTES to in-flight bytes in window mode and removes SEG_BYTES from credit in the other modes.
- R4: At most one segment is sent per clock. Eligibility is judged on the state at the start of the cycle. The search starts at the flow after the last one served (flow 0 first after reset) and wraps. The result appears on tx_valid/tx_flow/tx_seg after that clock edge.
- R5: In window mode, an acknowledgement for a flow raises its window by SEG_BYTES, capped at WIN_MAX. If in-flight bytes were at least SEG_BYTES, it also lowers in-flight bytes by SEG_BYTES. A congestion notice sets the window to half its value at the start of the cycle, but never below SEG_BYTES, and it overrides a simultaneous acknowledgement's window change.
- R6: In rate mode an internal tick fires on the TICK_PERIOD-th clock after reset and every TICK_PERIOD clocks after that. On a tick every flow's credit, after any send deduction in that cycle, gains RATE_BYTES, capped at BURST_MAX.
- R7: In grant mode a grant adds grant_bytes to the named flow's credit, after any send deduction in that cycle. The result saturates at 2^CREDIT_W-1.
- R8: Each transmit request is repeated one clock later on done_valid/done_flow/done_seg with the same flow and segment.
- R9: Acknowledgements and congestion notices have no effect in rate and grant mode. Grants have no effect in window and rate mode. Ticks have no effect in window and grant mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Enqueue a segment this cycle |
| enq_flow | input | FW | Flow to enqueue to |
| enq_seg | input | SEG_ID_W | Segment number to enqueue |
| ack_valid | input | 1 | Acknowledgement received |
| ack_flow | input | FW | Flow of the acknowledgement |
| cn_valid | input | 1 | Congestion notice received |
| cn_flow | input | FW | Flow of the congestion notice |
| grant_valid | input | 1 | Grant token received |
| grant_flow | input | FW | Flow of the grant |
| grant_bytes | input | CREDIT_W | Bytes carried by the grant |
| tx_valid | output | 1 | Transmit request valid |
| tx_flow | output | FW | Flow being sent |
| tx_seg | output | SEG_ID_W | Segment being sent |
| done_valid | output | 1 | Sent notice to the selector |
| done_flow | output | FW | Flow of the sent segment |
| done_seg | output | SEG_ID_W | Number of the sent segment |

## Verification
The hardest situation to reach is a full flow queue meeting a push in the same cycle as a send, while several other flows compete for the round-robin pointer.

The bench gets there in three steps:
- It drives a long burst of enqueues at one flow while withholding credit, so the queue fills and later pushes are discarded.
- It then releases feedback so the queue drains and the surviving order shows.
- A final phase loads every flow and refills credit on all of them every few cycles, so the arbiter rotates through full contention.

All three modes are built side by side and fed identical stimulus. This makes each mode's foreign feedback inputs arrive constantly and be seen to change nothing.

// File: rtl/ftx_sched_pkg.sv
package ftx_sched_pkg;
    typedef enum logic [1:0] {
        CM_WINDOW = 2'd0,
        CM_RATE   = 2'd1,
        CM_GRANT  = 2'd2
    } credit_mode_e;
endpackage

// File: rtl/ftx_seg_fifo.sv
module ftx_seg_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          nonempty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW:0]   FULL_C = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] LAST_C = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [AW:0]   cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic push_ok;

    always_comb begin
        s_d     = s_q;
        push_ok = push && (s_q.cnt != FULL_C);
        if (push_ok) s_d.wr = (s_q.wr == LAST_C) ? '0 : s_q.wr + 1'b1;
        if (pop)     s_d.rd = (s_q.rd == LAST_C) ? '0 : s_q.rd + 1'b1;
        s_d.cnt = s_q.cnt + (push_ok ? 1'b1 : 1'b0) - (pop ? 1'b1 : 1'b0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[s_q.wr] <= din;
    end

    assign dout     = mem_q[s_q.rd];
    assign nonempty = (s_q.cnt != '0);

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= FULL_C);
    a_r2_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (s_q.cnt != '0));
endmodule

// File: rtl/ftx_credit_unit.sv
module ftx_credit_unit
    import ftx_sched_pkg::*;
#(
    parameter credit_mode_e MODE = CM_WINDOW,
    parameter int CW         = 16,
    parameter int SEG_BYTES  = 100,
    parameter int WIN_MAX    = 400,
    parameter int RATE_BYTES = 50,
    parameter int BURST_MAX  = 300
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          send,
    input  logic          ack,
    input  logic          cn,
    input  logic          tick,
    input  logic          grant,
    input  logic [CW-1:0] grant_bytes,
    output logic          eligible
);
    localparam logic [CW-1:0] SEG_C   = CW'(SEG_BYTES);
    localparam logic [CW-1:0] WIN_C   = CW'(WIN_MAX);
    localparam logic [CW-1:0] RATE_C  = CW'(RATE_BYTES);
    localparam logic [CW-1:0] BURST_C = CW'(BURST_MAX);
    localparam logic [CW-1:0] ACC_RST = (MODE == CM_WINDOW) ? SEG_C : '0;

    typedef struct packed {
        logic [CW-1:0] acc;   // window (window mode) or byte credit
        logic [CW-1:0] infl;  // bytes in flight (window mode only)
    } cred_st_t;

    cred_st_t s_d, s_q;

    generate
        if (MODE == CM_WINDOW) begin : g_window
            logic [CW:0] need;
            logic unused_ok;
            assign unused_ok = ^{tick, grant, grant_bytes};
            always_comb begin
                s_d      = s_q;
                need     = {1'b0, s_q.infl} + {1'b0, SEG_C};
                eligible = (need <= {1'b0, s_q.acc});
                if (send) s_d.infl = s_q.infl + SEG_C;
                if (ack && (s_q.infl >= SEG_C)) s_d.infl = s_d.infl - SEG_C;
                if (ack) s_d.acc = (s_q.acc > WIN_C - SEG_C) ? WIN_C : s_q.acc + SEG_C;
                if (cn)  s_d.acc = ((s_q.acc >> 1) < SEG_C) ? SEG_C : (s_q.acc >> 1);
            end
            a_r5_window_bounds: assert property (@(posedge clk) disable iff (!rst_n)
                (s_q.acc >= SEG_C) && (s_q.acc <= WIN_C));
            a_r3_send_fits: assert property (@(posedge clk) disable iff (!rst_n)
                send |-> ({1'b0, s_q.infl} + {1'b0, SEG_C} <= {1'b0, s_q.acc}));
        end else if (MODE == CM_RATE) begin : g_rate
            logic [CW-1:0] base;
            logic [CW:0]   sum;
            logic unused_ok;
            assign unused_ok = ^{ack, cn, grant, grant_bytes};
            always_comb begin
                s_d      = s_q;
                eligible = (s_q.acc >= SEG_C);
                base     = s_q.acc - (send ? SEG_C : '0);
                sum      = {1'b0, base} + {1'b0, RATE_C};
                s_d.acc  = base;
                if (tick) s_d.acc = (sum > {1'b0, BURST_C}) ? BURST_C : sum[CW-1:0];
            end
            a_r6_burst_cap: assert property (@(posedge clk) disable iff (!rst_n)
                s_q.acc <= BURST_C);
            a_r3_send_covered: assert property (@(posedge clk) disable iff (!rst_n)
                send |-> (s_q.acc >= SEG_C));
        end else begin : g_grant
            logic [CW-1:0] base;
            logic [CW:0]   sum;
            logic unused_ok;
            assign unused_ok = ^{ack, cn, tick};
            always_comb begin
                s_d      = s_q;
                eligible = (s_q.acc >= SEG_C);
                base     = s_q.acc - (send ? SEG_C : '0);
                sum      = {1'b0, base} + {1'b0, grant_bytes};
                s_d.acc  = base;
                if (grant) s_d.acc = sum[CW] ? '1 : sum[CW-1:0];
            end
            a_r3_send_covered: assert property (@(posedge clk) disable iff (!rst_n)
                send |-> (s_q.acc >= SEG_C));
            a_r7_grant_grows: assert property (@(posedge clk) disable iff (!rst_n)
                (grant && !send) |=> (s_q.acc >= $past(s_q.acc)));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.acc  <= ACC_RST;
            s_q.infl <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/ftx_rr_pick.sv
module ftx_rr_pick #(
    parameter int N  = 4,
    parameter int FW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [FW-1:0] last,
    output logic [N-1:0]  gnt,
    output logic [FW-1:0] idx,
    output logic          any
);
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = 1; i <= N; i++) begin
            if (!any && req[FW'((int'(last) + i) % N)]) begin
                any = 1'b1;
                idx = FW'((int'(last) + i) % N);
                gnt[FW'((int'(last) + i) % N)] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ftx_sched.sv
module ftx_sched
    import ftx_sched_pkg::*;
#(
    parameter credit_mode_e MODE = CM_WINDOW,
    parameter int NUM_FLOWS   = 4,
    parameter int SEG_ID_W    = 8,
    parameter int QDEPTH      = 4,
    parameter int CREDIT_W    = 16,
    parameter int SEG_BYTES   = 100,
    parameter int WIN_MAX     = 400,
    parameter int RATE_BYTES  = 50,
    parameter int BURST_MAX   = 300,
    parameter int TICK_PERIOD = 8,
    localparam int FW = $clog2(NUM_FLOWS),
    localparam int TW = $clog2(TICK_PERIOD)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enq_valid,
    input  logic [FW-1:0]       enq_flow,
    input  logic [SEG_ID_W-1:0] enq_seg,
    input  logic                ack_valid,
    input  logic [FW-1:0]       ack_flow,
    input  logic                cn_valid,
    input  logic [FW-1:0]       cn_flow,
    input  logic                grant_valid,
    input  logic [FW-1:0]       grant_flow,
    input  logic [CREDIT_W-1:0] grant_bytes,
    output logic                tx_valid,
    output logic [FW-1:0]       tx_flow,
    output logic [SEG_ID_W-1:0] tx_seg,
    output logic                done_valid,
    output logic [FW-1:0]       done_flow,
    output logic [SEG_ID_W-1:0] done_seg
);
    localparam logic [TW-1:0] TICK_LAST = TW'(TICK_PERIOD - 1);
    localparam logic [FW-1:0] RR_RST    = FW'(NUM_FLOWS - 1);

    typedef struct packed {
        logic [FW-1:0]       rr_last;
        logic [TW-1:0]       tick_cnt;
        logic                tx_v;
        logic [FW-1:0]       tx_f;
        logic [SEG_ID_W-1:0] tx_s;
        logic                dn_v;
        logic [FW-1:0]       dn_f;
        logic [SEG_ID_W-1:0] dn_s;
    } top_st_t;

    top_st_t s_d, s_q;
    logic [NUM_FLOWS-1:0] nonempty, cred_ok, elig, gnt;
    logic [SEG_ID_W-1:0]  head [NUM_FLOWS];
    logic [FW-1:0]        pick_idx;
    logic                 pick_any;
    logic                 tick;

    assign tick = (s_q.tick_cnt == TICK_LAST);

    for (genvar i = 0; i < NUM_FLOWS; i++) begin : g_flow
        ftx_seg_fifo #(.DEPTH(QDEPTH), .DW(SEG_ID_W)) u_q (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (enq_valid && (enq_flow == FW'(i))),
            .pop      (gnt[i]),
            .din      (enq_seg),
            .dout     (head[i]),
            .nonempty (nonempty[i])
        );
        ftx_credit_unit #(
            .MODE(MODE), .CW(CREDIT_W), .SEG_BYTES(SEG_BYTES), .WIN_MAX(WIN_MAX),
            .RATE_BYTES(RATE_BYTES), .BURST_MAX(BURST_MAX)
        ) u_cred (
            .clk         (clk),
            .rst_n       (rst_n),
            .send        (gnt[i]),
            .ack         (ack_valid && (ack_flow == FW'(i))),
            .cn          (cn_valid && (cn_flow == FW'(i))),
            .tick        (tick),
            .grant       (grant_valid && (grant_flow == FW'(i))),
            .grant_bytes (grant_bytes),
            .eligible    (cred_ok[i])
        );
        assign elig[i] = nonempty[i] && cred_ok[i];
    end

    ftx_rr_pick #(.N(NUM_FLOWS), .FW(FW)) u_pick (
        .req  (elig),
        .last (s_q.rr_last),
        .gnt  (gnt),
        .idx  (pick_idx),
        .any  (pick_any)
    );

    always_comb begin
        s_d          = s_q;
        s_d.tick_cnt = tick ? '0 : s_q.tick_cnt + 1'b1;
        s_d.tx_v     = pick_any;
        s_d.tx_f     = pick_idx;
        s_d.tx_s     = head[pick_idx];
        if (pick_any) s_d.rr_last = pick_idx;
        s_d.dn_v     = s_q.tx_v;
        s_d.dn_f     = s_q.tx_f;
        s_d.dn_s     = s_q.tx_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.rr_last <= RR_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_valid   = s_q.tx_v;
    assign tx_flow    = s_q.tx_f;
    assign tx_seg     = s_q.tx_s;
    assign done_valid = s_q.dn_v;
    assign done_flow  = s_q.dn_f;
    assign done_seg   = s_q.dn_s;

    a_r4_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    a_r3_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~elig) == '0);
    a_r8_done_echo: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> (done_valid && done_flow == $past(tx_flow) && done_seg == $past(tx_seg)));
    a_r6_tick_range: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.tick_cnt <= TICK_LAST);
endmodule

// File: tb/ftx_sched_test.sv
`timescale 1ns/1ps
module ftx_sched_test;
    import ftx_sched_pkg::*;

    localparam int NF = 4, DEPTH = 4, SEG = 100, WINMAX = 400, RATE = 50;
    localparam int BURST = 300, PERIOD = 8, CMAX = 65535;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic       enq_valid = 0, ack_valid = 0, cn_valid = 0, grant_valid = 0;
    logic [1:0] enq_flow = 0, ack_flow = 0, cn_flow = 0, grant_flow = 0;
    logic [7:0] enq_seg = 0;
    logic [15:0] grant_bytes = 0;

    logic       tx_v [3];
    logic [1:0] tx_f [3];
    logic [7:0] tx_s [3];
    logic       dn_v [3];
    logic [1:0] dn_f [3];
    logic [7:0] dn_s [3];

    ftx_sched #(.MODE(CM_WINDOW)) uut (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_flow(enq_flow), .enq_seg(enq_seg),
        .ack_valid(ack_valid), .ack_flow(ack_flow), .cn_valid(cn_valid), .cn_flow(cn_flow),
        .grant_valid(grant_valid), .grant_flow(grant_flow), .grant_bytes(grant_bytes),
        .tx_valid(tx_v[0]), .tx_flow(tx_f[0]), .tx_seg(tx_s[0]),
        .done_valid(dn_v[0]), .done_flow(dn_f[0]), .done_seg(dn_s[0]));
    ftx_sched #(.MODE(CM_RATE)) uut_rate (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_flow(enq_flow), .enq_seg(enq_seg),
        .ack_valid(ack_valid), .ack_flow(ack_flow), .cn_valid(cn_valid), .cn_flow(cn_flow),
        .grant_valid(grant_valid), .grant_flow(grant_flow), .grant_bytes(grant_bytes),
        .tx_valid(tx_v[1]), .tx_flow(tx_f[1]), .tx_seg(tx_s[1]),
        .done_valid(dn_v[1]), .done_flow(dn_f[1]), .done_seg(dn_s[1]));
    ftx_sched #(.MODE(CM_GRANT)) uut_grant (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_flow(enq_flow), .enq_seg(enq_seg),
        .ack_valid(ack_valid), .ack_flow(ack_flow), .cn_valid(cn_valid), .cn_flow(cn_flow),
        .grant_valid(grant_valid), .grant_flow(grant_flow), .grant_bytes(grant_bytes),
        .tx_valid(tx_v[2]), .tx_flow(tx_f[2]), .tx_seg(tx_s[2]),
        .done_valid(dn_v[2]), .done_flow(dn_f[2]), .done_seg(dn_s[2]));

    // reference model state
    int m_acc [3][NF];
    int m_infl[3][NF];
    int mq    [3][NF][$];
    int m_last[3];
    int e_tv[3], e_tf[3], e_ts[3], e_dv[3], e_df[3], e_ds[3];
    int cyc = 0;
    int vectors = 0, errors = 0;
    bit finished = 0;
    string ptag = "R3";
    string mtag [3] = '{"R5", "R6", "R7"};

    task automatic model_step();
        bit tick = ((cyc % PERIOD) == PERIOD - 1);
        for (int m = 0; m < 3; m++) begin
            int pick = -1;
            bit el [NF];
            for (int f = 0; f < NF; f++)
                el[f] = (mq[m][f].size() > 0) &&
                        ((m == 0) ? (m_infl[m][f] + SEG <= m_acc[m][f]) : (m_acc[m][f] >= SEG));
            for (int k = 1; k <= NF; k++)
                if (pick < 0 && el[(m_last[m] + k) % NF]) pick = (m_last[m] + k) % NF;
            e_dv[m] = e_tv[m]; e_df[m] = e_tf[m]; e_ds[m] = e_ts[m];
            e_tv[m] = (pick >= 0);
            if (pick >= 0) begin
                e_tf[m] = pick;
                e_ts[m] = mq[m][pick][0];
                m_last[m] = pick;
            end
            if (enq_valid && mq[m][enq_flow].size() < DEPTH)
                mq[m][enq_flow].push_back(int'(enq_seg));
            if (pick >= 0) void'(mq[m][pick].pop_front());
            for (int f = 0; f < NF; f++) begin
                int sent = (pick == f) ? SEG : 0;
                if (m == 0) begin
                    int old_acc = m_acc[m][f];
                    int old_inf = m_infl[m][f];
                    m_infl[m][f] = old_inf + sent;
                    if (ack_valid && ack_flow == f && old_inf >= SEG) m_infl[m][f] -= SEG;
                    if (ack_valid && ack_flow == f)
                        m_acc[m][f] = (old_acc + SEG > WINMAX) ? WINMAX : old_acc + SEG;
                    if (cn_valid && cn_flow == f)
                        m_acc[m][f] = (old_acc / 2 < SEG) ? SEG : old_acc / 2;
                end else if (m == 1) begin
                    m_acc[m][f] -= sent;
                    if (tick) m_acc[m][f] = (m_acc[m][f] + RATE > BURST) ? BURST : m_acc[m][f] + RATE;
                end else begin
                    m_acc[m][f] -= sent;
                    if (grant_valid && grant_flow == f) begin
                        m_acc[m][f] += int'(grant_bytes);
                        if (m_acc[m][f] > CMAX) m_acc[m][f] = CMAX;
                    end
                end
            end
        end
        cyc++;
    endtask

    task automatic compare();
        for (int m = 0; m < 3; m++) begin
            vectors++;
            if (tx_v[m] !== e_tv[m][0] ||
                (e_tv[m] != 0 && (int'(tx_f[m]) != e_tf[m] || int'(tx_s[m]) != e_ts[m]))) begin
                errors++;
                $display("FAIL %s/%s mode%0d cyc%0d tx: actual v=%0d f=%0d s=%0d expected v=%0d f=%0d s=%0d",
                         ptag, mtag[m], m, cyc, tx_v[m], tx_f[m], tx_s[m], e_tv[m], e_tf[m], e_ts[m]);
            end
            vectors++;
            if (dn_v[m] !== e_dv[m][0] ||
                (e_dv[m] != 0 && (int'(dn_f[m]) != e_df[m] || int'(dn_s[m]) != e_ds[m]))) begin
                errors++;
                $display("FAIL R8 mode%0d cyc%0d done: actual v=%0d f=%0d s=%0d expected v=%0d f=%0d s=%0d",
                         m, cyc, dn_v[m], dn_f[m], dn_s[m], e_dv[m], e_df[m], e_ds[m]);
            end
        end
    endtask

    task automatic drive(int phase, int n);
        enq_valid = 0; ack_valid = 0; cn_valid = 0; grant_valid = 0;
        case (phase)
            0: begin  // mixed random traffic
                enq_valid = ($urandom_range(0, 1) == 1);
                enq_flow = 2'($urandom_range(0, 3)); enq_seg = 8'($urandom_range(0, 255));
                ack_valid = ($urandom_range(0, 9) < 3); ack_flow = 2'($urandom_range(0, 3));
                cn_valid = ($urandom_range(0, 9) == 0); cn_flow = 2'($urandom_range(0, 3));
                grant_valid = ($urandom_range(0, 9) < 3); grant_flow = 2'($urandom_range(0, 3));
                grant_bytes = 16'($urandom_range(0, 250));
            end
            1: begin  // flood one flow with no feedback
                enq_valid = 1; enq_flow = 2'd1; enq_seg = 8'(n);
            end
            2: begin  // drain with every feedback kind present
                ack_valid = ($urandom_range(0, 1) == 1); ack_flow = 2'($urandom_range(0, 3));
                cn_valid = ($urandom_range(0, 19) == 0); cn_flow = 2'($urandom_range(0, 3));
                grant_valid = ($urandom_range(0, 1) == 1); grant_flow = 2'($urandom_range(0, 3));
                grant_bytes = 16'($urandom_range(100, 300));
            end
            default: begin  // full contention on all flows
                enq_valid = 1; enq_flow = 2'(n); enq_seg = 8'(n + 7);
                ack_valid = 1; ack_flow = 2'(n + 1);
                grant_valid = 1; grant_flow = 2'(n + 2); grant_bytes = 16'd400;
            end
        endcase
    endtask

    task automatic run_phase(int phase, int cycles, string tag);
        ptag = tag;
        for (int n = 0; n < cycles; n++) begin
            @(negedge clk);
            compare();
            drive(phase, n);
            model_step();
        end
    endtask

    initial begin
        for (int m = 0; m < 3; m++) begin
            m_last[m] = NF - 1;
            e_tv[m] = 0; e_tf[m] = 0; e_ts[m] = 0; e_dv[m] = 0; e_df[m] = 0; e_ds[m] = 0;
            for (int f = 0; f < NF; f++) begin
                m_acc[m][f] = (m == 0) ? SEG : 0;
                m_infl[m][f] = 0;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int m = 0; m < 3; m++) begin  // R1 reset state
            vectors++;
            if (tx_v[m] !== 1'b0 || dn_v[m] !== 1'b0) begin
                errors++;
                $display("FAIL R1 mode%0d reset: actual tx=%0d done=%0d expected 0 0", m, tx_v[m], dn_v[m]);
            end
        end
        drive(0, 0);
        model_step();
        run_phase(0, 600, "R3");
        run_phase(1, 60, "R2");
        run_phase(2, 300, "R9");
        run_phase(3, 300, "R4");
        run_phase(0, 200, "R3");
        @(negedge clk);
        compare();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: actual hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule